// File: doc/BRIEF.md
# Data-Cache Store Scheduler

This block arbitrates a single-ported data-cache SRAM for an in-order pipeline. Every cycle the pipeline presents the class of the instruction at the issue point and a flag. The flag is set when that instruction consumes the result of the instruction issued just before it. The block answers in the same cycle. It says whether the instruction must be held, and whether the cache performs a read or a write in that cycle.

A load hit needs the cache for one cycle. A store hit is a read-modify-write: one read cycle on issue, then a fixed number of write cycles (two by default). These write cycles run in the background. Instructions that do not touch the cache issue freely during them. A load or store that arrives while writes are still pending is held until the bus is free. An instruction that consumes the result of the load just before it is held for one cycle.

The pipeline must keep the same instruction at its inputs while `stall` is high. It advances on the first clock edge at which `stall` is low.

Top module: `dcs_rmw_sched`

## Requirements
- R1: While reset is held and after its release, with no store pending, `stall`, `dc_read` and `dc_write` are low for a non-memory instruction.
- R2: Instruction class encoding on `op_class`: 0 is non-memory, 1 is load, 2 is store, 3 is treated as non-memory. An unstalled load or store drives `dc_read` high for exactly that cycle. A stalled instruction and a non-memory instruction never drive `dc_read`.
- R3: An instruction with `op_uses_load` high, issued right after a load, is stalled for exactly one cycle.
- R4: An issued store drives `dc_write` high in the two cycles after its issue cycle, and `dc_read` and `dc_write` are never high together.
- R5: A load immediately after a store is stalled for two cycles.
- R6: A store, one non-memory instruction, then a load gives one stall cycle.
- R7: A store followed by two non-memory instructions and then a load gives no stall cycle.
- R8: A store immediately after a store is stalled for two cycles.
- R9: A non-memory instruction never stalls because of pending store writes. It stalls only through the load-use rule.
- R10: `op_uses_load` high on an instruction whose predecessor was not a load causes no stall. Stall causes combine as a logical OR and are never added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 2 | Class of the instruction at the issue point |
| op_uses_load | input | 1 | Instruction consumes the previous load's result |
| stall | output | 1 | Hold the instruction at the issue point |
| dc_read | output | 1 | Cache read (load access or store read phase) this cycle |
| dc_write | output | 1 | Cache write phase of a store this cycle |

## Verification
A busy counter left with a wrong value shows up within one cycle as a `dc_write` pulse with no store before it. If a load or store is waiting, it also shows up as a stall of the wrong length. A load-use flag that is stuck set or cleared turns into an extra or a missing stall the first time a dependent instruction arrives. The reference model therefore compares all three outputs on every cycle of each store/load spacing, so a divergence is reported in the cycle it occurs.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_RSVD  = 2'd3
  } op_class_e;
endpackage

// File: rtl/dcs_busy_track.sv
// Counts outstanding write phases of the most recent store.
module dcs_busy_track #(
  parameter int WR_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic store_go,
  output logic busy
);
  localparam int CW = $clog2(WR_STATES + 1);
  localparam logic [CW-1:0] LOADV = CW'(WR_STATES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (store_go) begin
      cnt_d  = LOADV;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dcs_loaduse.sv
// Remembers whether the last issued instruction was a load.
module dcs_loaduse (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic is_load,
  input  logic uses_load,
  output logic hazard
);
  logic pend_q, pend_d;

  always_comb begin
    // a stall cycle consumes the pending load-use slot
    pend_d = issue ? is_load : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign hazard = pend_q & uses_load;
endmodule

// File: rtl/dcs_rmw_sched.sv
module dcs_rmw_sched #(
  parameter int WR_STATES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_class,
  input  logic       op_uses_load,
  output logic       stall,
  output logic       dc_read,
  output logic       dc_write
);
  import dcs_pkg::*;

  logic is_load, is_store, is_mem;
  logic busy, hazard, bus_hold, issue;

  assign is_load  = (op_class == OP_LOAD);
  assign is_store = (op_class == OP_STORE);
  assign is_mem   = is_load | is_store;

  dcs_busy_track #(.WR_STATES(WR_STATES)) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .store_go (issue & is_store),
    .busy     (busy)
  );

  dcs_loaduse u_lu (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .is_load   (is_load),
    .uses_load (op_uses_load),
    .hazard    (hazard)
  );

  assign bus_hold = is_mem & busy;
  assign stall    = hazard | bus_hold;
  assign issue    = ~stall;
  assign dc_read  = issue & is_mem;
  assign dc_write = busy;
endmodule

// File: rtl/dcs_rmw_sched_chk.sv
module dcs_rmw_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] op_class,
  input logic       op_uses_load,
  input logic       stall,
  input logic       dc_read,
  input logic       dc_write
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  logic ld_iss, st_iss, memop;
  assign ld_iss = (op_class == 2'd1) && !stall;
  assign st_iss = (op_class == 2'd2) && !stall;
  assign memop  = (op_class == 2'd1) || (op_class == 2'd2);

  assert_read_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dc_read |-> (memop && !stall));

  assert_store_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_iss |=> dc_write);

  assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dc_read && dc_write));

  assert_loaduse_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(ld_iss) && op_uses_load) |-> stall);

  assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_write && memop) |-> stall);

  assert_nonmem_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !memop && !$past(ld_iss)) |-> !stall);
endmodule

bind dcs_rmw_sched dcs_rmw_sched_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_class     (op_class),
  .op_uses_load (op_uses_load),
  .stall        (stall),
  .dc_read      (dc_read),
  .dc_write     (dc_write)
);

// File: tb/sim_dcs_rmw_sched.sv
`timescale 1ns/1ps
module sim_dcs_rmw_sched;
  logic       clk;
  logic       rst_n;
  logic [1:0] op_class;
  logic       op_uses_load;
  logic       stall, dc_read, dc_write;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int busy_left = 0;
  bit prev_load = 0;

  dcs_rmw_sched u0 (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .op_uses_load(op_uses_load),
    .stall(stall), .dc_read(dc_read), .dc_write(dc_write)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: present instruction, compare against the model, advance at the edge.
  task automatic step(input logic [1:0] c, input logic u, output bit stalled);
    bit mem, e_stall, e_rd, e_wr;
    @(negedge clk);
    op_class = c; op_uses_load = u;
    #1;
    mem     = (c == 2'd1) || (c == 2'd2);
    e_stall = (prev_load && u) || (mem && busy_left > 0);
    e_rd    = !e_stall && mem;
    e_wr    = busy_left > 0;
    chk("R3/R5/R8/R9/R10", stall, e_stall, "stall");
    chk("R2", dc_read, e_rd, "dc_read");
    chk("R4", dc_write, e_wr, "dc_write");
    if (dc_read && dc_write) chk("R4", 1'b1, 1'b0, "read and write together");
    @(posedge clk);
    if (!e_stall) begin
      prev_load = (c == 2'd1);
      if (c == 2'd2) busy_left = 2;
      else if (busy_left > 0) busy_left--;
    end else begin
      prev_load = 0;
      if (busy_left > 0) busy_left--;
    end
    stalled = stall;
  endtask

  // Issue one instruction, holding it while stalled; returns stall cycles seen.
  task automatic issue(input logic [1:0] c, input logic u, output int n);
    bit s;
    n = 0;
    do begin
      step(c, u, s);
      if (s) n++;
    end while (s && n < 10);
  endtask

  task automatic run4(input string req, input logic [1:0] c0, input logic [1:0] c1,
                      input logic [1:0] c2, input logic [1:0] c3,
                      input logic [3:0] u, input int exp_stalls);
    int n, tot;
    tot = 0;
    issue(c0, u[0], n); tot += n;
    issue(c1, u[1], n); tot += n;
    issue(c2, u[2], n); tot += n;
    issue(c3, u[3], n); tot += n;
    chk_int(req, tot, exp_stalls, "stall cycles in sequence");
    for (int k = 0; k < 3; k++) issue(2'd0, 1'b0, n);
  endtask

  initial begin
    bit s;
    int n;
    rst_n = 0; op_class = 2'd2; op_uses_load = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    op_class = 2'd0; op_uses_load = 1'b0;
    #1;
    chk("R1", stall, 1'b0, "stall in reset");
    chk("R1", dc_read, 1'b0, "dc_read in reset");
    chk("R1", dc_write, 1'b0, "dc_write in reset");
    @(posedge clk); #1 rst_n = 1;
    step(2'd0, 1'b0, s);

    // R2: single load, read for one cycle, class 3 behaves as non-memory
    run4("R2", 2'd1, 2'd0, 2'd3, 2'd1, 4'b0000, 0);
    // R3: load then dependent instruction
    run4("R3", 2'd1, 2'd0, 2'd0, 2'd0, 4'b0010, 1);
    run4("R3", 2'd1, 2'd1, 2'd0, 2'd0, 4'b0010, 1);
    // R4/R7: store hidden behind two non-memory ops
    run4("R7", 2'd2, 2'd0, 2'd0, 2'd1, 4'b0000, 0);
    // R5: store then load
    run4("R5", 2'd2, 2'd1, 2'd0, 2'd0, 4'b0000, 2);
    // R6: store, non-memory, load
    run4("R6", 2'd2, 2'd0, 2'd1, 2'd0, 4'b0000, 1);
    // R8: store then store
    run4("R8", 2'd2, 2'd2, 2'd0, 2'd0, 4'b0000, 2);
    // R9: non-memory ops during pending writes
    run4("R9", 2'd2, 2'd0, 2'd3, 2'd0, 4'b0000, 0);
    // R10: uses_load without preceding load
    run4("R10", 2'd0, 2'd2, 2'd0, 2'd0, 4'b0110, 0);
    // R10: store, load (2 bus stalls), dependent op (1 load-use stall), OR not sum
    run4("R10", 2'd2, 2'd1, 2'd1, 2'd0, 4'b0100, 3);
    // back-to-back loads, dependent second load
    run4("R3", 2'd1, 2'd1, 2'd1, 2'd0, 4'b0110, 2);
    issue(2'd0, 1'b0, n);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule